// File: doc/BRIEF.md
# Front-End Link Input Checker

This block terminates one serial front-end data link on the collector side. It takes one bit per clock. It finds the start of each word, removes the framing bit and sorts the words into packet headers, packet body words and single-word messages. Each data packet is checked against a running event counter. An accepted packet is rebuilt in an internal word FIFO as a three-word prefix (word count, front-end identifier, data format descriptor) followed by the original header and body. A downstream reader pops the FIFO and sees a packet only after its prefix has been written.

A header with an unknown code, or with an event number that does not equal the expected one, takes the link out of readout. While the link is out, each trigger pulse writes a placeholder packet with the data-lost flag set, for the event the link failed to deliver. A resynchronization command names the event number at which acceptance restarts. Placeholders fill the gap up to that number, and a header carrying it brings the link back. Messages go to a separate byte output. The throttle flag of the last accepted header drives a throttle request.

The word decoder has two states. In HUNT it waits for a 1 bit. In SHIFT it collects a 17-bit frame: a flag bit, then bits 15 down to 0. The transition SHIFT to SHIFT (framed) is taken after a data header without the empty flag, or after a body word whose flag is 1. Every other completed frame goes SHIFT to HUNT. The packer has six states:
- IDLE decodes headers, messages and triggers. IDLE to BODY on a stored header that has a body. IDLE to PFX_CNT on a stored header without a body, or on a placeholder. IDLE to SKIP on a rejected header that has a body.
- BODY copies body words and moves to PFX_CNT on the last one.
- SKIP discards words and returns to IDLE on the last one.
- PFX_CNT, PFX_ID and PFX_DD write the three prefix words in that order. PFX_DD publishes the packet to the reader and returns to IDLE.

Top module: `fe_link_rx`

## Requirements
- R1: A frame is a flag bit followed by 16 data bits, MSB first. Outside a packet, zero bits are idle and a 1 bit starts a header frame. Inside a packet, a flag of 1 means more words follow and a flag of 0 marks the last word. The flag is never stored.
- R2: Each stored packet occupies consecutive FIFO words in this order: word count (header plus body words), `fe_id`, `fe_dd`, the header, then the body words in arrival order.
- R3: A data header has code bits [15:12] = 4'b0110 and carries its event number in bits [7:0]. It is accepted while the link is in readout only if that number equals the expected one. Each acceptance advances the expected number by one, modulo 256.
- R4: A header whose code is neither data nor message (4'b1110), or a data header with the wrong event number, drops `link_on` and is not stored. Its body is skipped. Data headers received while the link is out and not resynchronizing are discarded.
- R5: While the link is out, each `trig` pulse stores a placeholder packet: count 1, `fe_id`, `fe_dd`, header 16'h6A00 with the expected event number in bits [7:0]. Each placeholder advances the expected number. While the link is in readout, `trig` has no effect.
- R6: Status bits are [11] empty, [10] throttle, [9] data lost, [8] error. A header with status exactly 4'b1000 is dropped (still advancing the sequence) unless `keep_empty` is 1. In that case it is stored with count 1, as is any empty header with another status bit set.
- R7: A message header (code 4'b1110) pulses `msg_vld` for one cycle with bits [7:0] on `msg_byte` and writes nothing to the FIFO.
- R8: `throttle` equals bit [10] of the most recently accepted data header.
- R9: A `resync` pulse takes the link out and sets a target event number from `resync_evt`. Trigger placeholders continue only while the expected number differs from the target. A data header carrying the target is then accepted, returns `link_on` to 1 and sets the expected number to target plus one.
- R10: After reset the FIFO is empty, `link_on` is 1, `throttle` is 0 and the first accepted event number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one link bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial link bit |
| trig | input | 1 | Trigger pulse; produces a placeholder while the link is out |
| resync | input | 1 | Resynchronization command pulse |
| resync_evt | input | 8 | Event number at which acceptance restarts |
| keep_empty | input | 1 | Keep empty packets with all-zero status |
| fe_id | input | 16 | Front-end identifier written in the prefix |
| fe_dd | input | 16 | Data format descriptor written in the prefix |
| rd_en | input | 1 | Pop one FIFO word |
| rd_data | output | 16 | FIFO head word |
| rd_valid | output | 1 | A published word is available |
| msg_vld | output | 1 | Message byte strobe |
| msg_byte | output | 8 | Message payload |
| throttle | output | 1 | Throttle request toward trigger gating |
| link_on | output | 1 | Link is in readout |

## Verification
The assertions assume a well-spaced environment. Frames arrive at least 17 cycles apart. Trigger and resync pulses fall only while the packer is idle and no word is completing. The reader drains fast enough that reserved and published words never exceed the FIFO depth. The stimulus keeps to this by leaving idle bits after every packet, waiting several cycles after each trigger pulse, and popping the FIFO on every cycle in which a word is visible. Expected FIFO contents come from a running event number in the bench, including a sweep past the 8-bit wrap.

// File: rtl/fe_link_pkg.sv
package fe_link_pkg;
    localparam int WORD_W = 16;
    localparam int EVT_W  = 8;

    localparam logic [3:0] CODE_DATA = 4'b0110;
    localparam logic [3:0] CODE_MSG  = 4'b1110;

    localparam logic [3:0] ST_EMPTY_ONLY = 4'b1000;
    localparam logic [3:0] ST_PLACEHOLD  = 4'b1010;
    localparam int         THR_BIT       = 10;

    typedef enum logic {DS_HUNT, DS_SHIFT} ds_state_t;

    typedef enum logic [2:0] {
        PK_IDLE, PK_BODY, PK_SKIP, PK_PFX_CNT, PK_PFX_ID, PK_PFX_DD
    } pk_state_t;
endpackage

// File: rtl/fe_link_deser.sv
module fe_link_deser import fe_link_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic              w_vld,
    output logic              w_first,
    output logic              w_last,
    output logic [WORD_W-1:0] w_data
);
    localparam int FRAME_W = WORD_W + 1;
    localparam int CW      = $clog2(FRAME_W + 1);

    ds_state_t          st, st_nx;
    logic [WORD_W-1:0]  sreg;
    logic [CW-1:0]      bcnt;
    logic               first_q;
    logic [FRAME_W-1:0] frame;
    logic               done, cont;

    always_comb begin
        frame = {sreg, ser_in};
        done  = (st == DS_SHIFT) && (bcnt == CW'(FRAME_W - 1));
        if (first_q)
            cont = (frame[WORD_W-1 -: 4] == CODE_DATA) && !frame[WORD_W-5];
        else
            cont = frame[WORD_W];
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            DS_HUNT:  st_nx = ser_in ? DS_SHIFT : DS_HUNT;
            DS_SHIFT: if (done) st_nx = cont ? DS_SHIFT : DS_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= DS_HUNT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg    <= '0;
            bcnt    <= '0;
            first_q <= 1'b0;
            w_vld   <= 1'b0;
            w_first <= 1'b0;
            w_last  <= 1'b0;
            w_data  <= '0;
        end else begin
            w_vld <= done;
            if (done) begin
                w_data  <= frame[WORD_W-1:0];
                w_first <= first_q;
                w_last  <= !cont;
            end
            if (st == DS_HUNT) begin
                if (ser_in) begin
                    sreg    <= WORD_W'(1);
                    bcnt    <= CW'(1);
                    first_q <= 1'b1;
                end
            end else if (done) begin
                bcnt    <= '0;
                first_q <= 1'b0;
            end else begin
                sreg <= {sreg[WORD_W-2:0], ser_in};
                bcnt <= bcnt + CW'(1);
            end
        end
    end

    AST_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        w_vld |=> !w_vld); // R1
endmodule

// File: rtl/fe_link_fifo.sv
module fe_link_fifo import fe_link_pkg::*; #(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW:0]       commit,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [AW:0]       rptr
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                rptr <= '0;
        else if (rd_en && rd_valid) rptr <= rptr + (AW+1)'(1);
    end

    always_comb begin
        rd_valid = (rptr != commit);
        rd_data  = mem[rptr[AW-1:0]];
    end
endmodule

// File: rtl/fe_link_pack.sv
module fe_link_pack import fe_link_pkg::*; #(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_vld,
    input  logic              w_first,
    input  logic              w_last,
    input  logic [WORD_W-1:0] w_data,
    input  logic              trig,
    input  logic              resync,
    input  logic [EVT_W-1:0]  resync_evt,
    input  logic              keep_empty,
    input  logic [WORD_W-1:0] fe_id,
    input  logic [WORD_W-1:0] fe_dd,
    input  logic [AW:0]       rptr,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [WORD_W-1:0] wdata,
    output logic [AW:0]       commit,
    output logic              msg_vld,
    output logic [EVT_W-1:0]  msg_byte,
    output logic              throttle,
    output logic              link_on
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    pk_state_t          st, st_nx;
    logic [PW-1:0]      wptr, base, wp3;
    logic [WORD_W-1:0]  cnt;
    logic [EVT_W-1:0]   exp_evt, target;
    logic               armed;

    logic [3:0]         hcode, hstat;
    logic [EVT_W-1:0]   hevt;
    logic               is_hdr, accept, store, fault, ph;

    always_comb begin
        hcode  = w_data[WORD_W-1 -: 4];
        hstat  = w_data[WORD_W-5 -: 4];
        hevt   = w_data[EVT_W-1:0];
        is_hdr = (st == PK_IDLE) && w_vld && w_first;
        accept = is_hdr && (hcode == CODE_DATA) &&
                 (link_on ? (hevt == exp_evt) : (armed && hevt == target));
        store  = accept && !(hstat == ST_EMPTY_ONLY && !keep_empty);
        fault  = is_hdr && link_on && (hcode != CODE_MSG) &&
                 ((hcode != CODE_DATA) || (hevt != exp_evt));
        ph     = (st == PK_IDLE) && !w_vld && trig && !link_on &&
                 !(armed && exp_evt == target);
        wp3    = wptr + PW'(3);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PK_IDLE: begin
                if (is_hdr) begin
                    if (store)        st_nx = w_last ? PK_PFX_CNT : PK_BODY;
                    else if (!w_last) st_nx = PK_SKIP;
                end else if (ph) begin
                    st_nx = PK_PFX_CNT;
                end
            end
            PK_BODY:    if (w_vld && w_last) st_nx = PK_PFX_CNT;
            PK_SKIP:    if (w_vld && w_last) st_nx = PK_IDLE;
            PK_PFX_CNT: st_nx = PK_PFX_ID;
            PK_PFX_ID:  st_nx = PK_PFX_DD;
            PK_PFX_DD:  st_nx = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= PK_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        we    = 1'b0;
        waddr = wptr[AW-1:0];
        wdata = w_data;
        unique case (st)
            PK_IDLE: begin
                waddr = wp3[AW-1:0];
                if (is_hdr) begin
                    we = store;
                end else if (ph) begin
                    we    = 1'b1;
                    wdata = {CODE_DATA, ST_PLACEHOLD, exp_evt};
                end
            end
            PK_BODY:    we = w_vld;
            PK_SKIP:    we = 1'b0;
            PK_PFX_CNT: begin we = 1'b1; waddr = base[AW-1:0];           wdata = cnt;   end
            PK_PFX_ID:  begin we = 1'b1; waddr = base[AW-1:0] + AW'(1); wdata = fe_id; end
            PK_PFX_DD:  begin we = 1'b1; waddr = base[AW-1:0] + AW'(2); wdata = fe_dd; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            base     <= '0;
            commit   <= '0;
            cnt      <= '0;
            exp_evt  <= '0;
            target   <= '0;
            armed    <= 1'b0;
            link_on  <= 1'b1;
            throttle <= 1'b0;
            msg_vld  <= 1'b0;
            msg_byte <= '0;
        end else begin
            msg_vld <= is_hdr && (hcode == CODE_MSG);
            if (is_hdr && hcode == CODE_MSG) msg_byte <= w_data[EVT_W-1:0];
            if ((st == PK_IDLE) && (store || (!is_hdr && ph))) begin
                base <= wptr;
                wptr <= wptr + PW'(4);
                cnt  <= WORD_W'(1);
            end
            if (st == PK_BODY && w_vld) begin
                wptr <= wptr + PW'(1);
                cnt  <= cnt + WORD_W'(1);
            end
            if (st == PK_PFX_DD) commit <= wptr;
            if (accept) begin
                exp_evt  <= hevt + EVT_W'(1);
                throttle <= w_data[THR_BIT];
                if (!link_on) begin
                    link_on <= 1'b1;
                    armed   <= 1'b0;
                end
            end else if (ph) begin
                exp_evt <= exp_evt + EVT_W'(1);
            end
            if (fault) begin
                link_on <= 1'b0;
                armed   <= 1'b0;
            end
            if (resync) begin
                link_on <= 1'b0;
                armed   <= 1'b1;
                target  <= resync_evt;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        PW'(wptr - rptr) <= PW'(DEPTH)); // R2
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hdr && link_on && w_data[15:12] == CODE_DATA && w_data[7:0] == exp_evt)
        |=> (exp_evt == $past(exp_evt) + 8'd1)); // R3
    AST_LINK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hdr && link_on && w_data[15:12] == CODE_DATA && w_data[7:0] != exp_evt)
        |=> !link_on); // R4
    AST_TRIG_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PK_IDLE && trig && !w_vld && link_on) |=> (wptr == $past(wptr))); // R5
    AST_MSG_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        msg_vld |-> (wptr == $past(wptr))); // R7
endmodule

// File: rtl/fe_link_rx.sv
module fe_link_rx import fe_link_pkg::*; #(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              trig,
    input  logic              resync,
    input  logic [7:0]        resync_evt,
    input  logic              keep_empty,
    input  logic [15:0]       fe_id,
    input  logic [15:0]       fe_dd,
    input  logic              rd_en,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic              msg_vld,
    output logic [7:0]        msg_byte,
    output logic              throttle,
    output logic              link_on
);
    logic              w_vld, w_first, w_last;
    logic [WORD_W-1:0] w_data;
    logic              we;
    logic [AW-1:0]     waddr;
    logic [WORD_W-1:0] wdata;
    logic [AW:0]       commit, rptr;

    fe_link_deser u_deser (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
        .w_vld(w_vld), .w_first(w_first), .w_last(w_last), .w_data(w_data)
    );

    fe_link_pack #(.AW(AW)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .w_vld(w_vld), .w_first(w_first), .w_last(w_last), .w_data(w_data),
        .trig(trig), .resync(resync), .resync_evt(resync_evt),
        .keep_empty(keep_empty), .fe_id(fe_id), .fe_dd(fe_dd), .rptr(rptr),
        .we(we), .waddr(waddr), .wdata(wdata), .commit(commit),
        .msg_vld(msg_vld), .msg_byte(msg_byte),
        .throttle(throttle), .link_on(link_on)
    );

    fe_link_fifo #(.AW(AW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .commit(commit), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .rptr(rptr)
    );
endmodule

// File: tb/fe_link_rx_tb.sv
module fe_link_rx_tb;
    localparam logic [15:0] ID = 16'h0A5A;
    localparam logic [15:0] DD = 16'hD00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0, trig = 1'b0, resync = 1'b0, keep_empty = 1'b0;
    logic [7:0]  resync_evt = 8'd0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid, msg_vld, throttle, link_on;
    logic [7:0]  msg_byte;

    int checks = 0, failures = 0;
    bit finished = 1'b0;
    logic [15:0] got  [4096];
    logic [15:0] expw [4096];
    logic [7:0]  mgot [64];
    int gn = 0, en = 0, mn = 0, cmp_idx = 0;
    logic [7:0] m_exp = 8'd0;

    always #2.5 clk = ~clk;

    fe_link_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .trig(trig),
        .resync(resync), .resync_evt(resync_evt), .keep_empty(keep_empty),
        .fe_id(ID), .fe_dd(DD), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .msg_vld(msg_vld), .msg_byte(msg_byte),
        .throttle(throttle), .link_on(link_on)
    );

    always @(negedge clk) begin
        if (rst_n && rd_valid && gn < 4096) begin
            got[gn] = rd_data;
            gn++;
        end
        rd_en = rd_valid;
        if (rst_n && msg_vld && mn < 64) begin
            mgot[mn] = msg_byte;
            mn++;
        end
    end

    task automatic check(input string req, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, a, e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            ser_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic send_word(input logic flag, input logic [15:0] d);
        ser_in = flag;
        @(negedge clk);
        for (int i = 15; i >= 0; i--) begin
            ser_in = d[i];
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] body(input logic [7:0] evt, input int i);
        return {evt ^ 8'h3C, 8'(i * 37 + 5)};
    endfunction

    task automatic send_pkt(input logic [7:0] hs, input logic [7:0] evt, input int n, input int gap);
        send_word(1'b1, {hs, evt});
        for (int i = 0; i < n; i++) send_word(i != n - 1, body(evt, i));
        idle(gap);
    endtask

    task automatic push_exp(input logic [15:0] w);
        expw[en] = w;
        en++;
    endtask

    task automatic expect_pkt(input logic [15:0] hdr, input int n);
        push_exp(16'(n + 1));
        push_exp(ID);
        push_exp(DD);
        push_exp(hdr);
        for (int i = 0; i < n; i++) push_exp(body(hdr[7:0], i));
    endtask

    task automatic compare(input string req);
        idle(40);
        check({req, " count"}, gn, en);
        for (int i = cmp_idx; i < en; i++) check(req, got[i], expw[i]);
        cmp_idx = en;
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        idle(8);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 rd_valid", rd_valid, 0);
        check("R10 link_on", link_on, 1);
        check("R10 throttle", throttle, 0);

        // R1 R2 R3 R6: sweep across the 8-bit wrap, varying body length and idle gaps
        for (int k = 0; k < 300; k++) begin
            int n = k % 4;
            if (n == 0) begin
                send_pkt(8'h68, m_exp, 0, k % 3 + 1);
            end else begin
                send_pkt(8'h60, m_exp, n, k % 3 + 1);
                expect_pkt({8'h60, m_exp}, n);
            end
            m_exp++;
        end
        compare("R1 R2 R3 sweep");
        check("R3 link_on after wrap", link_on, 1);

        // R7 message word
        send_word(1'b1, 16'hE05C);
        idle(10);
        check("R7 msg count", mn, 1);
        check("R7 msg byte", mgot[0], 8'h5C);
        compare("R7 fifo untouched");

        // R8 throttle
        send_pkt(8'h64, m_exp, 1, 6);
        expect_pkt({8'h64, m_exp}, 1);
        m_exp++;
        check("R8 throttle set", throttle, 1);
        send_pkt(8'h60, m_exp, 2, 6);
        expect_pkt({8'h60, m_exp}, 2);
        m_exp++;
        check("R8 throttle clear", throttle, 0);

        // R6 empty packets
        keep_empty = 1'b1;
        send_pkt(8'h68, m_exp, 0, 6);
        expect_pkt({8'h68, m_exp}, 0);
        m_exp++;
        keep_empty = 1'b0;
        send_pkt(8'h69, m_exp, 0, 6);
        expect_pkt({8'h69, m_exp}, 0);
        m_exp++;
        compare("R6 R8 empty and throttle");

        // R4 event mismatch
        send_pkt(8'h60, m_exp + 8'd2, 2, 6);
        check("R4 link drop", link_on, 0);
        send_pkt(8'h60, m_exp, 1, 6);
        compare("R4 nothing stored");

        // R5 placeholders
        for (int i = 0; i < 3; i++) begin
            pulse_trig();
            expect_pkt({8'h6A, m_exp}, 0);
            m_exp++;
        end
        compare("R5 placeholders");

        // R9 resync to m_exp+3
        resync_evt = m_exp + 8'd3;
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        idle(4);
        for (int i = 0; i < 5; i++) begin
            pulse_trig();
            if (i < 3) begin
                expect_pkt({8'h6A, m_exp}, 0);
                m_exp++;
            end
        end
        check("R9 still out", link_on, 0);
        send_pkt(8'h60, m_exp, 2, 6);
        expect_pkt({8'h60, m_exp}, 2);
        m_exp++;
        check("R9 link back", link_on, 1);
        compare("R9 resync");

        // R5 trig inert while in readout
        pulse_trig();
        compare("R5 trig inert");

        // R4 unknown code
        send_pkt(8'h30, m_exp, 0, 6);
        check("R4 bad code drop", link_on, 0);
        compare("R4 bad code not stored");

        summary();
    end
endmodule